// File: doc/BRIEF.md
# Peak-Current PWM Cycle Controller

This block produces the on/off command for the high-side switch of a fixed-frequency buck stage that uses peak-current control. A counter that runs from the system clock marks out switching periods. The switch turns on at the start of every period. It turns off at the first of these events:

- the synchronised peak-current comparator trips;
- a cycle-by-cycle current-limit input trips;
- the maximum-duty point of the period is reached.

A minimum on-time applies after every turn-on. During that time both trip inputs are held back.

An 8-bit feedback code sets the length of each period. Full scale gives the nominal period, and zero gives a period about five times longer. Between the two the period is interpolated linearly. The frequency therefore folds back when the output is shorted and climbs back smoothly as feedback recovers. An inhibit input forces the switch off at once. After inhibit is released, switching resumes only on the period grid.

The analog parts of the loop stay outside the block: the comparator, the error amplifier and the slope compensation. The block sees them only as single-bit trip inputs and the feedback code.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: While reset is held, the gate output is low. After reset is released, the period counter starts from the folded (longest) period, and the first turn-on occurs exactly PER_FOLD clock cycles later.
- R2: The gate goes high only on the clock edge that follows the last count of a period. Consecutive turn-ons are exactly one period apart.
- R3: The feedback code f is an unsigned 8-bit value. It is sampled at each period start. The period in cycles is PER_FOLD - floor((PER_FOLD - PER_NOM) * f / 255). Code 255 gives PER_NOM, code 0 gives PER_FOLD, and one code step moves the period by at most one interpolation step.
- R4: The gate stays high for at most floor(period * DUTY_PCT / 100) cycles. With no trip, it stays high for exactly that many cycles.
- R5: The comparator input passes through a two-flop synchroniser. If it rises j cycles after turn-on, the gate is high for j+3 cycles, subject to R4 and R6.
- R6: Once on, the gate stays high for at least MIN_ON cycles. A trip seen earlier is remembered and ends the on-time at MIN_ON cycles.
- R7: The current-limit input has its own two-flop synchroniser and follows the same timing as the comparator. When both inputs trip, the earlier trip takes effect.
- R8: A trip input that rises while the gate is low has no effect. A trip input that stays high into the next period does not end that period's on-time.
- R9: The gate is low in the cycle after inhibit is seen high and stays low while inhibit is held. The period counter keeps running, and the first turn-on after release falls on the next period boundary of the unchanged grid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_code_i | input | FB_W | Digitised feedback, full scale at the regulation point |
| cmp_trip_i | input | 1 | Peak-current comparator output (asynchronous) |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit output (asynchronous) |
| inhibit_i | input | 1 | Forces the switch off while high |
| gate_o | output | 1 | Switch-on command, registered |

## Verification
Two pairs of events can fall in the same cycle. First, a comparator edge can land on the very cycle in which the maximum-duty count expires. The bench sweeps the trip delay across the whole on-time, so one step hits that cycle, and the pulse must end once at the duty limit. Second, the comparator and the current limit can trip together. The bench drives both at the same delay and expects exactly the single-trip width. The same sweep also covers a trip inside the minimum on-time, where the expected width is MIN_ON.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;

    localparam int PCC_CNT_W = 16;

    typedef struct packed {
        logic [PCC_CNT_W-1:0] cnt;
        logic [PCC_CNT_W-1:0] per;
        logic [PCC_CNT_W-1:0] maxon;
    } timer_st_t;

    typedef struct packed {
        logic       gate;
        logic       trip;
        logic [1:0] prev;
    } gate_st_t;

endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_i;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcc_period_calc.sv
module pcc_period_calc
    import pcm_pwm_pkg::*;
#(
    parameter int FB_W     = 8,
    parameter int PER_NOM  = 658,
    parameter int PER_FOLD = 3125,
    parameter int DUTY_PCT = 93
) (
    input  logic [FB_W-1:0]      fb_i,
    output logic [PCC_CNT_W-1:0] per_o,
    output logic [PCC_CNT_W-1:0] maxon_o
);
    localparam int FB_MAX = (1 << FB_W) - 1;
    localparam int SPAN   = PER_FOLD - PER_NOM;
    localparam int PW     = PCC_CNT_W + FB_W;
    localparam int DW     = PCC_CNT_W + 8;

    logic [PW-1:0] span_prod;
    logic [PW-1:0] span_quot;
    logic [DW-1:0] duty_prod;

    always_comb begin
        span_prod = PW'(SPAN) * PW'(fb_i);
        span_quot = span_prod / PW'(FB_MAX);
        per_o     = PCC_CNT_W'(PER_FOLD) - PCC_CNT_W'(span_quot);
        duty_prod = DW'(per_o) * DW'(DUTY_PCT);
        maxon_o   = PCC_CNT_W'(duty_prod / DW'(100));
    end
endmodule

// File: rtl/pcc_period_timer.sv
module pcc_period_timer
    import pcm_pwm_pkg::*;
#(
    parameter int PER_RST   = 3125,
    parameter int MAXON_RST = 2906
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [PCC_CNT_W-1:0] per_next_i,
    input  logic [PCC_CNT_W-1:0] maxon_next_i,
    output logic [PCC_CNT_W-1:0] cnt_o,
    output logic [PCC_CNT_W-1:0] per_o,
    output logic [PCC_CNT_W-1:0] maxon_o,
    output logic                 wrap_o
);
    timer_st_t tm_d, tm_q;

    always_comb begin
        tm_d   = tm_q;
        wrap_o = (tm_q.cnt == tm_q.per - PCC_CNT_W'(1));
        if (wrap_o) begin
            tm_d.cnt   = '0;
            tm_d.per   = per_next_i;
            tm_d.maxon = maxon_next_i;
        end else begin
            tm_d.cnt   = tm_q.cnt + PCC_CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tm_q.cnt   <= '0;
            tm_q.per   <= PCC_CNT_W'(PER_RST);
            tm_q.maxon <= PCC_CNT_W'(MAXON_RST);
        end else begin
            tm_q <= tm_d;
        end
    end

    assign cnt_o   = tm_q.cnt;
    assign per_o   = tm_q.per;
    assign maxon_o = tm_q.maxon;
endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
    import pcm_pwm_pkg::*;
#(
    parameter int FB_W     = 8,
    parameter int PER_NOM  = 658,
    parameter int PER_FOLD = 3125,
    parameter int MIN_ON   = 50,
    parameter int DUTY_PCT = 93
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [FB_W-1:0] fb_code_i,
    input  logic            cmp_trip_i,
    input  logic            ilim_trip_i,
    input  logic            inhibit_i,
    output logic            gate_o
);
    localparam int MAXON_RST = (PER_FOLD * DUTY_PCT) / 100;

    logic [PCC_CNT_W-1:0] per_next, maxon_next;
    logic [PCC_CNT_W-1:0] pos_cnt, per_len, on_limit;
    logic                 period_wrap;
    logic [1:0]           trip_sync;
    logic [1:0]           trip_edge;
    logic [PCC_CNT_W:0]   on_after;
    logic                 trip_now;
    gate_st_t             gs_d, gs_q;

    pcc_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({ilim_trip_i, cmp_trip_i}),
        .sync_o  (trip_sync)
    );

    pcc_period_calc #(
        .FB_W(FB_W), .PER_NOM(PER_NOM), .PER_FOLD(PER_FOLD), .DUTY_PCT(DUTY_PCT)
    ) u_calc (
        .fb_i    (fb_code_i),
        .per_o   (per_next),
        .maxon_o (maxon_next)
    );

    pcc_period_timer #(.PER_RST(PER_FOLD), .MAXON_RST(MAXON_RST)) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .per_next_i   (per_next),
        .maxon_next_i (maxon_next),
        .cnt_o        (pos_cnt),
        .per_o        (per_len),
        .maxon_o      (on_limit),
        .wrap_o       (period_wrap)
    );

    always_comb begin
        gs_d      = gs_q;
        gs_d.prev = trip_sync;
        trip_edge = trip_sync & ~gs_q.prev;
        trip_now  = (|trip_edge) | gs_q.trip;
        on_after  = {1'b0, pos_cnt} + (PCC_CNT_W+1)'(1);
        if (inhibit_i) begin
            gs_d.gate = 1'b0;
            gs_d.trip = 1'b0;
        end else if (period_wrap) begin
            gs_d.gate = 1'b1;
            gs_d.trip = 1'b0;
        end else if (gs_q.gate) begin
            if (on_after >= {1'b0, on_limit}) begin
                gs_d.gate = 1'b0;
                gs_d.trip = 1'b0;
            end else if (trip_now && on_after >= (PCC_CNT_W+1)'(MIN_ON)) begin
                gs_d.gate = 1'b0;
                gs_d.trip = 1'b0;
            end else begin
                gs_d.trip = trip_now;
            end
        end else begin
            gs_d.trip = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gs_q.gate <= 1'b0;
            gs_q.trip <= 1'b0;
            gs_q.prev <= 2'b00;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign gate_o = gs_q.gate;
endmodule

// File: rtl/pcm_pwm_ctrl_chk.sv
module pcm_pwm_ctrl_chk #(
    parameter int PER_NOM  = 658,
    parameter int PER_FOLD = 3125,
    parameter int MIN_ON   = 50
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        inhibit_i,
    input logic        gate_o,
    input logic        wrap_i,
    input logic [15:0] per_i,
    input logic [15:0] maxon_i
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hi_cnt <= '0;
        else if (gate_o) hi_cnt <= hi_cnt + 16'd1;
        else             hi_cnt <= '0;
    end

    // R2
    turn_on_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> $past(wrap_i));

    // R9
    inhibit_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inhibit_i |=> !gate_o);

    // R6
    min_on_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(gate_o) && !$past(inhibit_i)) |-> (hi_cnt >= 16'(MIN_ON)));

    // R4
    max_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> (hi_cnt < maxon_i));

    // R3
    period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_i >= 16'(PER_NOM)) && (per_i <= 16'(PER_FOLD)));
endmodule

bind pcm_pwm_ctrl pcm_pwm_ctrl_chk #(
    .PER_NOM(PER_NOM), .PER_FOLD(PER_FOLD), .MIN_ON(MIN_ON)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_i (inhibit_i),
    .gate_o    (gate_o),
    .wrap_i    (period_wrap),
    .per_i     (per_len),
    .maxon_i   (on_limit)
);

// File: tb/pcm_pwm_ctrl_bench.sv
module pcm_pwm_ctrl_bench;
    localparam int NOM   = 20;
    localparam int FOLD  = 100;
    localparam int MINON = 6;
    localparam int DUTY  = 93;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fb = 8'hFF;
    logic       cmp = 1'b0;
    logic       lim = 1'b0;
    logic       inh = 1'b0;
    logic       gate;
    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int w, p, c0, cr, bad, expc;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_pwm_ctrl #(
        .FB_W(8), .PER_NOM(NOM), .PER_FOLD(FOLD), .MIN_ON(MINON), .DUTY_PCT(DUTY)
    ) u_pcm_pwm_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .fb_code_i(fb), .cmp_trip_i(cmp),
        .ilim_trip_i(lim), .inhibit_i(inh), .gate_o(gate)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_per(input int f);
        return FOLD - ((FOLD - NOM) * f) / 255;
    endfunction

    function automatic int exp_max(input int per);
        return (per * DUTY) / 100;
    endfunction

    function automatic int exp_trip(input int j, input int mx);
        int v;
        v = (j + 3 < MINON) ? MINON : j + 3;
        return (v > mx) ? mx : v;
    endfunction

    task automatic wait_rise();
        @(negedge clk);
        while (gate) @(negedge clk);
        while (!gate) @(negedge clk);
    endtask

    task automatic measure(output int wid, output int per);
        wid = 0; per = 0;
        while (gate) begin wid++; per++; @(negedge clk); end
        while (!gate) begin per++; @(negedge clk); end
    endtask

    task automatic pulse_trip(input int j, input bit uc, input bit ul, output int wid);
        wid = 0;
        for (int i = 0; gate; i++) begin
            if (i == j) begin cmp = uc; lim = ul; end
            wid++;
            @(negedge clk);
        end
        cmp = 1'b0; lim = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(gate == 1'b0, "R1 reset gate", int'(gate), 0);
        rst_n = 1'b1;
        c0 = cyc;
        wait_rise();
        chk(cyc == c0 + FOLD, "R1 first turn-on", cyc - c0, FOLD);

        // R3 R4 R2: sweep every feedback code, no trips
        for (int f = 0; f < 256; f++) begin
            fb = 8'(f);
            wait_rise();
            measure(w, p);
            chk(p == exp_per(f), "R3 period", p, exp_per(f));
            chk(w == exp_max(exp_per(f)), "R4 duty cap", w, exp_max(exp_per(f)));
        end

        // R5 R6: comparator delay sweep at nominal period (includes trip on the duty-limit cycle)
        fb = 8'hFF;
        wait_rise();
        wait_rise();
        for (int j = 0; j < 20; j++) begin
            pulse_trip(j, 1'b1, 1'b0, w);
            chk(w == exp_trip(j, exp_max(NOM)), (j + 3 < MINON) ? "R6 min on" : "R5 cmp width",
                w, exp_trip(j, exp_max(NOM)));
            wait_rise();
        end

        // R7: current-limit delay sweep, then both together
        for (int j = 0; j < 20; j++) begin
            pulse_trip(j, 1'b0, 1'b1, w);
            chk(w == exp_trip(j, exp_max(NOM)), "R7 limit width", w, exp_trip(j, exp_max(NOM)));
            wait_rise();
        end
        pulse_trip(5, 1'b1, 1'b1, w);
        chk(w == exp_trip(5, exp_max(NOM)), "R7 both trips", w, exp_trip(5, exp_max(NOM)));
        wait_rise();
        pulse_trip(15, 1'b1, 1'b1, w);
        chk(w == exp_max(NOM), "R7 both at duty limit", w, exp_max(NOM));

        // R8: trip rising while off, held high through the next period
        fb = 8'h00;
        wait_rise();
        while (gate) @(negedge clk);
        cmp = 1'b1;
        while (!gate) @(negedge clk);
        w = 0;
        while (gate) begin w++; @(negedge clk); end
        chk(w == exp_max(FOLD), "R8 off-time trip ignored", w, exp_max(FOLD));
        cmp = 1'b0;

        // R9: inhibit mid-pulse, held across boundaries, release off-grid
        fb = 8'hFF;
        wait_rise();
        wait_rise();
        c0 = cyc;
        @(negedge clk);
        @(negedge clk);
        inh = 1'b1;
        @(negedge clk);
        chk(gate == 1'b0, "R9 inhibit next cycle", int'(gate), 0);
        bad = 0;
        repeat (49) begin
            @(negedge clk);
            if (gate) bad++;
        end
        chk(bad == 0, "R9 held off", bad, 0);
        cr = cyc;
        inh = 1'b0;
        while (!gate) @(negedge clk);
        expc = c0 + ((cr + 1 - c0 + NOM - 1) / NOM) * NOM;
        chk(cyc == expc, "R9 resume on grid", cyc - c0, expc - c0);

        finish_run();
    end
endmodule